// File: doc/BRIEF.md
# Packed-Lane Immediate Left Shifter

This unit takes one wide vector value and shifts every packed lane in it left by the same immediate amount. It returns the result one clock later. The caller supplies a 4-bit lane-size code, split into a high pair and a low pair of bits, and a 3-bit immediate.

The unit reads the code and the immediate together as one 7-bit field. The most significant set bit of the code picks the lane width: 8, 16, 32 or 64 bits. The shift amount is the 7-bit field minus that lane width, so the amount always lies below the lane width.

An all-zero code is an undefined encoding. A low enable input also makes the request undefined. In either case the unit raises an undefined flag alongside its valid strobe and drives a zero result.

Top module: `vec_lshift_imm`

## Requirements
- R1: The size code is `{size_hi, size_lo}`, with `size_hi` in bits 3:2. A request with a code of 4'b0000 returns `undef_o` = 1 together with `valid_o`, and `result_o` = 0.
- R2: The lane width is 8 when the code is 4'b0001, 16 for 4'b001x, 32 for 4'b01xx and 64 for 4'b1xxx.
- R3: The shift amount equals the unsigned value of `{code, imm}` minus the lane width, giving 0 up to the lane width minus 1.
- R4: Each lane is shifted logically left on its own. Bits leaving the top of a lane are dropped, zeros enter at the bottom, and no bit crosses into a neighbouring lane.
- R5: Every lane of the vector is processed. Lane 0 occupies the least significant bits.
- R6: When `en` is low at the request, the result is undefined (`undef_o` = 1, `result_o` = 0) whatever the fields hold.
- R7: `valid_o` is high in exactly the cycle after each cycle in which `in_valid` is high, including back-to-back requests.
- R8: After reset, `valid_o` = 0, `undef_o` = 0 and `result_o` = 0.
- R9: `undef_o` is never high without `valid_o`, and `result_o` holds its last value during cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Unit enable; low makes every request undefined |
| in_valid | input | 1 | Request strobe |
| size_hi | input | 2 | Upper two bits of the size code |
| size_lo | input | 2 | Lower two bits of the size code |
| imm | input | 3 | Low three bits of the packed width/shift field |
| src | input | VLEN | Source vector |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| undef_o | output | 1 | Undefined-encoding flag, qualified by `valid_o` |
| result_o | output | VLEN | Shifted vector, zero when undefined |

## Verification
The assertions check the handshake on every cycle: one-cycle latency, the undefined flag implying valid and a zero result, zero codes and a low enable forcing the flag, and a zero shift on byte lanes returning the source unchanged. Only the bench's scenarios can show that the lane data is correct. It sweeps every code and immediate over several source patterns and compares each result with a bit-level reference. Directed cases cover lane isolation, lane order, result hold while idle, and the reset state.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
    localparam int NUM_WIDTHS = 4;
    localparam int MIN_LANE   = 8;
    localparam int MAX_LANE   = MIN_LANE << (NUM_WIDTHS - 1);
    localparam int SHW        = $clog2(MAX_LANE);

    typedef enum logic [1:0] {
        LW_8  = 2'd0,
        LW_16 = 2'd1,
        LW_32 = 2'd2,
        LW_64 = 2'd3
    } lane_w_e;
endpackage

// File: rtl/lsl_field_decode.sv
module lsl_field_decode
    import lsl_pkg::*;
(
    input  logic [3:0]     code,
    input  logic [2:0]     imm,
    input  logic           en,
    output lane_w_e        width_sel,
    output logic [SHW-1:0] shamt,
    output logic           bad
);
    logic [6:0] packed_f;
    logic [6:0] lane_bits;
    logic [6:0] diff;

    always_comb begin
        if (code[3])      width_sel = LW_64;
        else if (code[2]) width_sel = LW_32;
        else if (code[1]) width_sel = LW_16;
        else              width_sel = LW_8;
        packed_f  = {code, imm};
        lane_bits = 7'(MIN_LANE) << width_sel;
        diff      = packed_f - lane_bits;
        shamt     = diff[SHW-1:0];
        bad       = (code == 4'b0000) || !en;
    end
endmodule

// File: rtl/lsl_lane_shift.sv
module lsl_lane_shift
    import lsl_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic [VLEN-1:0] src,
    input  lane_w_e         width_sel,
    input  logic [SHW-1:0]  shamt,
    output logic [VLEN-1:0] dst
);
    logic [NUM_WIDTHS-1:0][VLEN-1:0] cand;

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        localparam int LW = MIN_LANE << g;
        localparam int NL = VLEN / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] lane_in;
            assign lane_in = src[l*LW +: LW];
            assign cand[g][l*LW +: LW] = lane_in << shamt;
        end
    end

    assign dst = cand[width_sel];
endmodule

// File: rtl/vec_lshift_imm.sv
module vec_lshift_imm
    import lsl_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            in_valid,
    input  logic [1:0]      size_hi,
    input  logic [1:0]      size_lo,
    input  logic [2:0]      imm,
    input  logic [VLEN-1:0] src,
    output logic            valid_o,
    output logic            undef_o,
    output logic [VLEN-1:0] result_o
);
    if (VLEN % MAX_LANE != 0 || VLEN < MAX_LANE) begin : g_vlen_bad
        $error("VLEN must be a positive multiple of the widest lane");
    end

    typedef struct packed {
        logic            valid;
        logic            undef;
        logic [VLEN-1:0] result;
    } state_t;

    state_t          st_d, st_q;
    lane_w_e         width_sel;
    logic [SHW-1:0]  shamt;
    logic            bad;
    logic [VLEN-1:0] shifted;

    lsl_field_decode i_dec (
        .code      ({size_hi, size_lo}),
        .imm       (imm),
        .en        (en),
        .width_sel (width_sel),
        .shamt     (shamt),
        .bad       (bad)
    );

    lsl_lane_shift #(.VLEN(VLEN)) i_shift (
        .src       (src),
        .width_sel (width_sel),
        .shamt     (shamt),
        .dst       (shifted)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.undef = 1'b0;
        if (in_valid) begin
            st_d.undef  = bad;
            st_d.result = bad ? '0 : shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o  = st_q.valid;
    assign undef_o  = st_q.undef;
    assign result_o = st_q.result;
endmodule

// File: rtl/vec_lshift_imm_chk.sv
module vec_lshift_imm_chk #(
    parameter int VLEN = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            in_valid,
    input logic [1:0]      size_hi,
    input logic [1:0]      size_lo,
    input logic [2:0]      imm,
    input logic [VLEN-1:0] src,
    input logic            valid_o,
    input logic            undef_o,
    input logic [VLEN-1:0] result_o
);
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> valid_o);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !valid_o);
    p_undef_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> valid_o);
    p_undef_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> (result_o == '0));
    p_zero_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && {size_hi, size_lo} == 4'b0000) |=> undef_o);
    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !en) |=> undef_o);
    p_byte_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && en && {size_hi, size_lo} == 4'b0001 && imm == 3'd0)
        |=> (result_o == $past(src)));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result_o));
endmodule

bind vec_lshift_imm vec_lshift_imm_chk #(.VLEN(VLEN)) i_chk (.*);

// File: tb/test_vec_lshift_imm.sv
module test_vec_lshift_imm;
    localparam int VL     = 256;
    localparam int CLK_PD = 10;
    localparam int NPAT   = 5;
    localparam logic [VL-1:0] PATS [NPAT] = '{
        {256{1'b1}},
        {32{8'hA5}},
        {16{16'h8001}},
        {4{64'hDEAD_BEEF_0123_4567}},
        {8{32'h7F00_FF01}}
    };

    logic          clk = 0, rst_n = 0, en = 1, in_valid = 0;
    logic [1:0]    size_hi = 0, size_lo = 0;
    logic [2:0]    imm = 0;
    logic [VL-1:0] src = '0;
    logic          valid_o, undef_o;
    logic [VL-1:0] result_o;
    int            n_chk = 0, n_bad = 0;
    bit            done = 0;

    always #(CLK_PD/2) clk = ~clk;

    vec_lshift_imm #(.VLEN(VL)) i_vec_lshift_imm (.*);

    function automatic logic [VL-1:0] ref_lsl(input logic [VL-1:0] s,
                                               input logic [3:0] code,
                                               input logic [2:0] im);
        int w, sh;
        logic [VL-1:0] r;
        w  = code[3] ? 64 : code[2] ? 32 : code[1] ? 16 : 8;
        sh = int'(code) * 8 + int'(im) - w;
        r  = '0;
        for (int i = 0; i < VL; i++)
            if ((i % w) >= sh) r[i] = s[i - sh];
        return r;
    endfunction

    task automatic check(input string tag, input logic v, input logic u,
                         input logic [VL-1:0] res);
        n_chk++;
        if (valid_o !== v || undef_o !== u || result_o !== res) begin
            n_bad++;
            $display("FAIL %s: got v=%b u=%b r=%h exp v=%b u=%b r=%h",
                     tag, valid_o, undef_o, result_o, v, u, res);
        end
    endtask

    task automatic drive(input logic [VL-1:0] s, input logic [3:0] code,
                         input logic [2:0] im, input logic e);
        @(negedge clk);
        src = s; {size_hi, size_lo} = code; imm = im; en = e; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin
        #(CLK_PD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [VL-1:0] keep;
        repeat (3) @(negedge clk);
        check("R8 reset", 1'b0, 1'b0, '0);
        rst_n = 1;

        // R1 R2 R3 R4 R5: sweep every code and immediate over each pattern
        for (int p = 0; p < NPAT; p++)
            for (int c = 0; c < 16; c++)
                for (int k = 0; k < 8; k++) begin
                    drive(PATS[p], 4'(c), 3'(k), 1'b1);
                    if (c == 0) check("R1 zero code", 1'b1, 1'b1, '0);
                    else check("R2 R3 R4 sweep", 1'b1, 1'b0,
                               ref_lsl(PATS[p], 4'(c), 3'(k)));
                end

        // R4: byte lanes of all ones, shift 7, no carry into next lane
        drive({256{1'b1}}, 4'b0001, 3'd7, 1'b1);
        check("R4 isolation", 1'b1, 1'b0, {32{8'h80}});

        // R5: lane 0 in LSBs, 64-bit lanes, shift 63
        drive({{255{1'b0}}, 1'b1}, 4'b1111, 3'd7, 1'b1);
        check("R5 lane order", 1'b1, 1'b0, {{192{1'b0}}, 1'b1, {63{1'b0}}});

        // R6: enable low overrides a legal code
        drive(PATS[3], 4'b0100, 3'd2, 1'b0);
        check("R6 disabled", 1'b1, 1'b1, '0);

        // R9: result holds while idle, no valid
        drive(PATS[1], 4'b0010, 3'd3, 1'b1);
        keep = ref_lsl(PATS[1], 4'b0010, 3'd3);
        check("R9 load", 1'b1, 1'b0, keep);
        repeat (3) @(negedge clk);
        check("R9 hold", 1'b0, 1'b0, keep);

        // R7: back-to-back requests
        @(negedge clk);
        src = PATS[2]; {size_hi, size_lo} = 4'b1000; imm = 3'd4; en = 1; in_valid = 1;
        @(negedge clk);
        check("R7 first", 1'b1, 1'b0, ref_lsl(PATS[2], 4'b1000, 3'd4));
        src = PATS[4]; {size_hi, size_lo} = 4'b0110; imm = 3'd1;
        @(negedge clk);
        in_valid = 0;
        check("R7 second", 1'b1, 1'b0, ref_lsl(PATS[4], 4'b0110, 3'd1));
        @(negedge clk);
        check("R7 idle", 1'b0, 1'b0, ref_lsl(PATS[4], 4'b0110, 3'd1));

        // R8: reset mid-run clears outputs
        drive(PATS[0], 4'b0011, 3'd5, 1'b1);
        rst_n = 0;
        #1;
        check("R8 reset again", 1'b0, 1'b0, '0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule